// File: doc/BRIEF.md
# Modulo-60 Cascaded Decimal Counter

This block counts enabled clock cycles in two decimal digits that share one clock: a units digit that runs 0 to 9 and a tens digit that runs 0 to 5. The tens digit moves only when the units digit wraps. Together they pass through 60 states, from 00 to 59 and back to 00. A carry output is high while the count stands at 59 and the enable is high. That carry can drive the enable input of a further counter, so a 60 Hz tick on `en` gives one carry per second.

Both digits are kept in one step-decision stage that is instantiated twice. On each enabled edge a stage takes one of three named actions. In HOLD it keeps its value. In STEP it adds one. In WRAP it goes back to zero from its last value. When enable is low every stage takes HOLD. When enable is high a stage below its last value takes STEP, and a stage at its last value takes WRAP. The tens stage counts to 5 and wraps to 0 on the same edge that the units digit wraps, so it never passes through a value of 6. The synchronous reset overrides every action.

Top module: `mod60_ticker`

## Requirements
- R1: With `rst` high at a rising edge, `units` and `tens` are both 0 after that edge, whatever the value of `en`.
- R2: With `en` high and `rst` low, a rising edge at which `units` is below 9 increments `units` by one.
- R3: With `en` high and `rst` low, a rising edge at which `units` is 9 sets `units` to 0 and advances `tens` by one (or wraps it per R5).
- R4: `tens` changes only on an enabled edge at which `units` is 9; on any other edge without reset it keeps its value.
- R5: An enabled edge at which the count is 59 (`tens` 5, `units` 9) takes both digits to 0 on that edge, with no intermediate tens value of 6.
- R6: `tc59` is high exactly while `tens` is 5, `units` is 9 and `en` is high, combinationally, in the same cycle.
- R7: With `en` low and `rst` low, an edge leaves `units` and `tens` unchanged, and `tc59` stays low even at count 59.
- R8: Starting from reset, `tc59` is high on exactly one enabled cycle in every 60 enabled cycles, the 60th, 120th, and so on.
- R9: `units` never exceeds 9 and `tens` never exceeds 5 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both digits |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; one count per high cycle |
| units | output | 4 | Units digit, 0 to 9 |
| tens | output | 3 | Tens digit, 0 to 5 |
| tc59 | output | 1 | Terminal count of the pair; enable for a following stage |

## Verification
The bench builds the block with its default moduli of 10 for the units and 6 for the tens, so the whole 60-state cycle takes 60 enabled clocks. A run of 130 enabled clocks crosses the 59-to-00 wrap twice and every units rollover more than ten times. The bench also holds the count at 59 with enable low, to show that the carry depends on the enable. Finally it resets in the middle of a count while enable is high, to show that reset takes priority over counting.

// File: rtl/mod60_pkg.sv
package mod60_pkg;

    // Action a digit stage takes at the next clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_WRAP = 2'd2
    } step_act_t;

endpackage

// File: rtl/digit_stage.sv
module digit_stage
    import mod60_pkg::*;
#(
    parameter int MODULUS = 10,
    parameter int WIDTH   = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    output logic [WIDTH-1:0] value,
    output logic             carry
);

    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    step_act_t act;
    logic      at_last;

    // Decide the action for the coming edge.
    always_comb begin
        at_last = (value == LAST);
        if (!step_en)
            act = ACT_HOLD;
        else if (at_last)
            act = ACT_WRAP;
        else
            act = ACT_STEP;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            unique case (act)
                ACT_HOLD: value <= value;
                ACT_STEP: value <= value + 1'b1;
                ACT_WRAP: value <= '0;
            endcase
        end
    end

    // Outputs: carry into the next stage.
    always_comb begin
        carry = at_last && step_en;
    end

endmodule

// File: rtl/mod60_ticker.sv
module mod60_ticker #(
    parameter  int UNITS_MOD = 10,
    parameter  int TENS_MOD  = 6,
    localparam int UW        = $clog2(UNITS_MOD),
    localparam int TW        = $clog2(TENS_MOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [UW-1:0] units,
    output logic [TW-1:0] tens,
    output logic          tc59
);

    logic units_carry;

    digit_stage #(
        .MODULUS (UNITS_MOD),
        .WIDTH   (UW)
    ) i_units (
        .clk     (clk),
        .rst     (rst),
        .step_en (en),
        .value   (units),
        .carry   (units_carry)
    );

    digit_stage #(
        .MODULUS (TENS_MOD),
        .WIDTH   (TW)
    ) i_tens (
        .clk     (clk),
        .rst     (rst),
        .step_en (units_carry),
        .value   (tens),
        .carry   (tc59)
    );

endmodule

// File: rtl/mod60_ticker_chk.sv
module mod60_ticker_chk #(
    parameter  int UNITS_MOD = 10,
    parameter  int TENS_MOD  = 6,
    localparam int UW        = $clog2(UNITS_MOD),
    localparam int TW        = $clog2(TENS_MOD)
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [UW-1:0] units,
    input logic [TW-1:0] tens,
    input logic          tc59
);

    localparam logic [UW-1:0] U_LAST = UW'(UNITS_MOD - 1);
    localparam logic [TW-1:0] T_LAST = TW'(TENS_MOD - 1);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (units == '0) && (tens == '0));

    p_units_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && units != U_LAST) |=> units == $past(units) + 1'b1);

    p_units_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (en && units == U_LAST) |=> units == '0);

    p_tens_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(en && units == U_LAST) |=> $stable(tens));

    p_wrap59_r5: assert property (@(posedge clk) disable iff (rst)
        (en && units == U_LAST && tens == T_LAST) |=> (tens == '0) && (units == '0));

    p_carry_r6: assert property (@(posedge clk) disable iff (rst)
        tc59 == (en && units == U_LAST && tens == T_LAST));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(units) && $stable(tens));

    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        (units <= U_LAST) && (tens <= T_LAST));

endmodule

bind mod60_ticker mod60_ticker_chk #(
    .UNITS_MOD (UNITS_MOD),
    .TENS_MOD  (TENS_MOD)
) i_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .units (units),
    .tens  (tens),
    .tc59  (tc59)
);

// File: tb/test_mod60_ticker.sv
module test_mod60_ticker;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] units;
    logic [2:0] tens;
    logic       tc59;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_u    = 0;
    int exp_t    = 0;
    int tc_seen  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mod60_ticker i_mod60_ticker (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .units (units),
        .tens  (tens),
        .tc59  (tc59)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, check carry before the edge, check digits after it.
    task automatic step(input logic en_v, input logic rst_v, input string tag);
        int exp_tc;
        @(negedge clk);
        en  = en_v;
        rst = rst_v;
        #1;
        exp_tc = (exp_t == 5 && exp_u == 9 && en_v) ? 1 : 0;
        chk(exp_tc ? "R8/R6" : tag, "tc59", int'(tc59), exp_tc);
        if (tc59) tc_seen++;
        @(posedge clk);
        #1;
        if (rst_v) begin
            exp_u = 0;
            exp_t = 0;
        end else if (en_v) begin
            if (exp_u == 9) begin
                exp_u = 0;
                exp_t = (exp_t == 5) ? 0 : exp_t + 1;
            end else begin
                exp_u = exp_u + 1;
            end
        end
        chk(tag, "units", int'(units), exp_u);
        chk(tag, "tens",  int'(tens),  exp_t);
        chk("R9", "range", int'(units <= 4'd9 && tens <= 3'd5), 1);
    endtask

    task automatic t_reset;
        step(1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        chk("R1", "units after reset", int'(units), 0);
        chk("R1", "tens after reset", int'(tens), 0);
    endtask

    task automatic t_long_run;
        tc_seen = 0;
        for (int k = 1; k <= 130; k++) begin
            if (exp_u == 9) step(1'b1, 1'b0, (exp_t == 5) ? "R5" : "R3");
            else            step(1'b1, 1'b0, "R2");
        end
        chk("R8", "carry pulses in 130 enabled clocks", tc_seen, 2);
        chk("R4", "tens after 130 clocks", int'(tens), 1);
        chk("R2", "units after 130 clocks", int'(units), 0);
    endtask

    task automatic t_enable_gaps;
        step(1'b0, 1'b1, "R1");
        for (int k = 0; k < 59; k++) begin
            step(1'b1, 1'b0, "R2");
            step(1'b0, 1'b0, "R7");
        end
        chk("R7", "tens at 59", int'(tens), 5);
        chk("R7", "units at 59", int'(units), 9);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, "R5");
        chk("R5", "tens after wrap", int'(tens), 0);
    endtask

    task automatic t_reset_midcount;
        for (int k = 0; k < 23; k++) step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, "R2");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset;
        t_long_run;
        t_enable_gaps;
        t_reset_midcount;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule